// File: doc/BRIEF.md
# Slow Memory Interface Configuration Register

This block is a single 32-bit configuration register for a slow external-memory interface, together with the small amount of logic that its bits control directly. Software writes it through a plain synchronous write strobe and sees its current contents on a read-data bus at all times. Four bits can be written. They select write protection for the attached flash devices, pick which of two chip selects answers the boot address window, and enable clock cutting for an internal memory and for an SDRAM controller. A fifth bit is read-only and shows the flash ready pin after it has been synchronised to the register clock.

The boot-mode bit is loaded from a strap pin on every clock edge while reset is held. After reset it stays writable by software. The bit exchanges the address windows of the two chip selects right away, so the decode outputs depend on the bus address and on the current boot-mode value. Clock enables go low only when the global power-down bit and the matching local enable are both set. An idle request is acknowledged one cycle later, and only while the internal-memory power-down bit is set.

Top module: `smcfg_top`

## Requirements
- R1: Bits 31 to 5 of the read data are always 0, whatever has been written to them.
- R2: Read bit 4 shows the flash ready pin through a two-stage synchronizer. A pin change made between two clock edges appears after the second following edge, not after the first.
- R3: Bit 3 (global power-down) resets to 0, is set or cleared by a write, and reads back the written value.
- R4: Bit 2 (internal-memory power-down) resets to 0, is set or cleared by a write, and reads back the written value.
- R5: Bit 1 (boot mode) takes the value of the strap pin while reset is low. After reset, writes can change it.
- R6: With boot mode 0, chip select A hits for addresses 0x0000_0000 to 0x01FF_FFFF and chip select B hits for 0x0C00_0000 to 0x0DFF_FFFF. With boot mode 1 the two windows are exchanged. An address outside both windows asserts neither hit, and the two hits are never high together.
- R7: A write that changes bit 1 leaves the decode unchanged in the write cycle and applies the new mapping from the next cycle. Bit 1 does not change in a cycle without a write.
- R8: Bit 0 (write protect) resets to 0, and the flash write-protect pin always equals it: 1 drives the pin high, 0 drives it low.
- R9: The internal-memory clock enable is low exactly when bits 3 and 2 are both 1. The SDRAM clock enable is low exactly when bit 3 and the SDRAM power-down input are both 1.
- R10: The idle acknowledge rises one cycle after the request while bit 2 is 1. It falls in the same cycle that either the request or bit 2 falls, and it is never high while bit 2 is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rstN | input | 1 | Synchronous active-low reset |
| regWe | input | 1 | Write strobe for the configuration register |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Current register contents |
| flashRdyPin | input | 1 | Flash ready pin, asynchronous |
| bootStrapPin | input | 1 | Boot-mode strap, sampled during reset |
| busAddr | input | 32 | Incoming bus address to decode |
| sdramPdEn | input | 1 | SDRAM power-down enable from its own register |
| idleReq | input | 1 | Idle request |
| selAHit | output | 1 | Chip select A decode hit |
| selBHit | output | 1 | Chip select B decode hit |
| flashWpPin | output | 1 | Flash write-protect pin level |
| imemClkEn | output | 1 | Internal-memory clock enable, low means cut |
| sdramClkEn | output | 1 | SDRAM clock enable, low means cut |
| idleAck | output | 1 | Idle acknowledge |

## Verification
The decode is driven from a table of addresses taken under both boot-mode values. The table covers the first and last byte of each window and the addresses just outside them, plus an address far from both, so a wrong window size, a missing swap or an overlap shows up as a wrong hit. Directed tests cover the remaining behaviour:
- all four combinations of the power-down bits, which separate an AND gate from an OR gate or from a single-bit gate;
- the idle request raised, dropped, and left high while its enable falls, which shows whether the acknowledge is registered on the way in and combinational on the way out;
- a pin toggle counted edge by edge, which fixes the synchronizer depth;
- a boot-mode write watched before and after its edge.

// File: rtl/smcfg_pkg.sv
package smcfg_pkg;
  localparam int CFG_W = 32;
  localparam int BIT_WP = 0;
  localparam int BIT_BOOT = 1;
  localparam int BIT_IMPD = 2;
  localparam int BIT_GPD = 3;
  localparam int BIT_RDY = 4;
  localparam int LIVE_W = 4;

  // Field order matches the register bit positions 3..0.
  typedef struct packed {
    logic globalPd;
    logic imemPd;
    logic bootMode;
    logic wrProt;
  } cfg_bits_t;

  typedef struct packed {
    logic cfgWr;
    logic strapLoad;
  } cfg_strobe_t;
endpackage

// File: rtl/smcfg_ctrl.sv
module smcfg_ctrl
  import smcfg_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWe,
  input  logic        idleReq,
  input  logic        imemPd,
  output cfg_strobe_t strobe,
  output logic        idleAck
);
  logic ackQ;
  logic ackCond;

  assign ackCond = idleReq & imemPd;

  always_comb begin
    strobe.strapLoad = ~rstN;
    strobe.cfgWr     = rstN & regWe;
  end

  always_ff @(posedge clk) begin
    if (!rstN) ackQ <= 1'b0;
    else       ackQ <= ackCond;
  end

  // Rises through the register, falls through the live condition.
  assign idleAck = ackQ & ackCond;
endmodule

// File: rtl/smcfg_dpath.sv
module smcfg_dpath
  import smcfg_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SYNC_STAGES = 2,
  parameter int WIN_LOG2 = 25,
  parameter logic [ADDR_W-1:0] LOW_BASE = '0,
  parameter logic [ADDR_W-1:0] HIGH_BASE = 32'h0C00_0000
) (
  input  logic              clk,
  input  cfg_strobe_t       strobe,
  input  logic [CFG_W-1:0]  regWdata,
  input  logic              flashRdyPin,
  input  logic              bootStrapPin,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              sdramPdEn,
  output logic [CFG_W-1:0]  regRdata,
  output cfg_bits_t         cfgBits,
  output logic              selAHit,
  output logic              selBHit,
  output logic              flashWpPin,
  output logic              imemClkEn,
  output logic              sdramClkEn
);
  localparam int TAG_W = ADDR_W - WIN_LOG2;
  localparam int NUM_WIN = 2;

  cfg_bits_t bitsQ;
  logic [SYNC_STAGES-1:0] syncQ;
  logic rdySync;
  logic [NUM_WIN-1:0] winHit;

  always_ff @(posedge clk) begin
    if (strobe.strapLoad) begin
      bitsQ.globalPd <= 1'b0;
      bitsQ.imemPd   <= 1'b0;
      bitsQ.bootMode <= bootStrapPin;
      bitsQ.wrProt   <= 1'b0;
    end else if (strobe.cfgWr) begin
      bitsQ <= cfg_bits_t'(regWdata[LIVE_W-1:0]);
    end
  end

  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk) syncQ <= flashRdyPin;
    end else begin : g_syncN
      always_ff @(posedge clk) syncQ <= {syncQ[SYNC_STAGES-2:0], flashRdyPin};
    end
  endgenerate
  assign rdySync = syncQ[SYNC_STAGES-1];

  generate
    for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
      localparam logic [ADDR_W-1:0] BASE = (w == 0) ? LOW_BASE : HIGH_BASE;
      assign winHit[w] = busAddr[ADDR_W-1 -: TAG_W] == BASE[ADDR_W-1 -: TAG_W];
    end
  endgenerate

  always_comb begin
    selAHit = bitsQ.bootMode ? winHit[1] : winHit[0];
    selBHit = bitsQ.bootMode ? winHit[0] : winHit[1];
  end

  assign flashWpPin = bitsQ.wrProt;
  assign imemClkEn  = ~(bitsQ.globalPd & bitsQ.imemPd);
  assign sdramClkEn = ~(bitsQ.globalPd & sdramPdEn);

  always_comb begin
    regRdata = '0;
    regRdata[LIVE_W-1:0] = bitsQ;
    regRdata[BIT_RDY] = rdySync;
  end

  assign cfgBits = bitsQ;
endmodule

// File: rtl/smcfg_top.sv
module smcfg_top
  import smcfg_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SYNC_STAGES = 2,
  parameter int WIN_LOG2 = 25,
  parameter logic [ADDR_W-1:0] LOW_BASE = '0,
  parameter logic [ADDR_W-1:0] HIGH_BASE = 32'h0C00_0000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata,
  input  logic              flashRdyPin,
  input  logic              bootStrapPin,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              sdramPdEn,
  input  logic              idleReq,
  output logic              selAHit,
  output logic              selBHit,
  output logic              flashWpPin,
  output logic              imemClkEn,
  output logic              sdramClkEn,
  output logic              idleAck
);
  cfg_strobe_t strobe;
  cfg_bits_t cfgBits;

  smcfg_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .regWe(regWe), .idleReq(idleReq),
    .imemPd(cfgBits.imemPd), .strobe(strobe), .idleAck(idleAck)
  );

  smcfg_dpath #(
    .ADDR_W(ADDR_W), .SYNC_STAGES(SYNC_STAGES), .WIN_LOG2(WIN_LOG2),
    .LOW_BASE(LOW_BASE), .HIGH_BASE(HIGH_BASE)
  ) u_dpath (
    .clk(clk), .strobe(strobe), .regWdata(regWdata),
    .flashRdyPin(flashRdyPin), .bootStrapPin(bootStrapPin),
    .busAddr(busAddr), .sdramPdEn(sdramPdEn), .regRdata(regRdata),
    .cfgBits(cfgBits), .selAHit(selAHit), .selBHit(selBHit),
    .flashWpPin(flashWpPin), .imemClkEn(imemClkEn), .sdramClkEn(sdramClkEn)
  );
endmodule

// File: rtl/smcfg_chk.sv
module smcfg_chk (
  input logic        clk,
  input logic        rstN,
  input logic        regWe,
  input logic [31:0] regRdata,
  input logic        flashRdyPin,
  input logic        selAHit,
  input logic        selBHit,
  input logic        flashWpPin,
  input logic        imemClkEn,
  input logic        sdramClkEn,
  input logic        sdramPdEn,
  input logic        idleReq,
  input logic        idleAck
);
  logic [1:0] age;
  always_ff @(posedge clk) begin
    if (!rstN) age <= '0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  // R1
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    regRdata[31:5] == '0);
  // R2
  rdy_sync_chk: assert property (@(posedge clk) disable iff (!rstN)
    (age >= 2'd2) |-> regRdata[4] == $past(flashRdyPin, 2));
  // R6
  sel_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(selAHit && selBHit));
  // R7
  boot_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !regWe |=> $stable(regRdata[1]));
  // R8
  wp_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    flashWpPin == regRdata[0]);
  // R9
  imem_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    imemClkEn == !(regRdata[3] && regRdata[2]));
  // R9
  sdram_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    sdramClkEn == !(regRdata[3] && sdramPdEn));
  // R10
  ack_needs_en_chk: assert property (@(posedge clk) disable iff (!rstN)
    idleAck |-> (idleReq && regRdata[2]));
  // R10
  ack_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    (idleReq && regRdata[2]) |=> (idleAck || !idleReq || !regRdata[2]));
endmodule

bind smcfg_top smcfg_chk u_chk (.*);

// File: tb/smcfg_top_test.sv
module smcfg_top_test;
  logic clk = 1'b0;
  logic rstN, regWe, flashRdyPin, bootStrapPin, sdramPdEn, idleReq;
  logic [31:0] regWdata, regRdata, busAddr;
  logic selAHit, selBHit, flashWpPin, imemClkEn, sdramClkEn, idleAck;
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  smcfg_top uut (.*);

  // {bootMode, address, expected A hit, expected B hit}  (R6)
  localparam logic [34:0] VEC [12] = '{
    {1'b0, 32'h0000_0000, 1'b1, 1'b0},
    {1'b0, 32'h01FF_FFFF, 1'b1, 1'b0},
    {1'b0, 32'h0200_0000, 1'b0, 1'b0},
    {1'b0, 32'h0BFF_FFFF, 1'b0, 1'b0},
    {1'b0, 32'h0C00_0000, 1'b0, 1'b1},
    {1'b0, 32'h0DFF_FFFF, 1'b0, 1'b1},
    {1'b0, 32'h0E00_0000, 1'b0, 1'b0},
    {1'b1, 32'h0000_0000, 1'b0, 1'b1},
    {1'b1, 32'h01FF_FFFF, 1'b0, 1'b1},
    {1'b1, 32'h0C00_0000, 1'b1, 1'b0},
    {1'b1, 32'h0DFF_FFFF, 1'b1, 1'b0},
    {1'b1, 32'hFFFF_FFFF, 1'b0, 1'b0}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic writeCfg(input logic [31:0] d);
    @(negedge clk);
    regWe = 1'b1;
    regWdata = d;
    @(negedge clk);
    regWe = 1'b0;
    #1;
  endtask

  task automatic doReset(input logic strap);
    @(negedge clk);
    rstN = 1'b0;
    bootStrapPin = strap;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rstN = 1'b0; regWe = 1'b0; regWdata = '0; flashRdyPin = 1'b0;
    bootStrapPin = 1'b1; sdramPdEn = 1'b0; idleReq = 1'b0; busAddr = '0;
    doReset(1'b1);
    // R3 R4 R5 R8 reset values, strap high
    check("R5 reset boot from strap", {28'd0, regRdata[3:0]}, 32'h2);
    check("R8 reset wp pin", {31'd0, flashWpPin}, 32'd0);
    check("R9 reset clock enables", {30'd0, imemClkEn, sdramClkEn}, 32'h3);
    check("R10 reset ack", {31'd0, idleAck}, 32'd0);
    check("R1 reset reserved", {5'd0, regRdata[31:5]}, 32'd0);

    // R1 reserved bits ignore ones; R3 R4 R8 read back
    writeCfg(32'hFFFF_FFFF);
    check("R1 reserved after all-ones write", {5'd0, regRdata[31:5]}, 32'd0);
    check("R3 R4 read back set", {28'd0, regRdata[3:0]}, 32'hF);
    check("R8 wp pin high", {31'd0, flashWpPin}, 32'd1);
    writeCfg(32'h0000_0002);
    check("R3 R4 read back clear", {28'd0, regRdata[3:0]}, 32'h2);
    check("R8 wp pin low", {31'd0, flashWpPin}, 32'd0);
    // R5 writable after reset
    writeCfg(32'h0);
    check("R5 boot cleared by write", {31'd0, regRdata[1]}, 32'd0);

    // R6 table walk
    for (int i = 0; i < 12; i++) begin
      writeCfg({30'd0, VEC[i][34], 1'b0});
      busAddr = VEC[i][33:2];
      #1;
      check($sformatf("R6 vec %0d", i), {30'd0, selAHit, selBHit}, {30'd0, VEC[i][1:0]});
    end

    // R7 boot write takes effect the cycle after
    writeCfg(32'h0);
    busAddr = 32'h0000_0000;
    @(negedge clk);
    regWe = 1'b1; regWdata = 32'h2;
    #1;
    check("R7 decode unchanged in write cycle", {30'd0, selAHit, selBHit}, 32'h2);
    @(negedge clk);
    regWe = 1'b0;
    #1;
    check("R7 decode swapped next cycle", {30'd0, selAHit, selBHit}, 32'h1);

    // R2 two-stage ready synchronizer
    @(negedge clk);
    flashRdyPin = 1'b1;
    @(negedge clk); #1;
    check("R2 ready after one edge", {31'd0, regRdata[4]}, 32'd0);
    @(negedge clk); #1;
    check("R2 ready after two edges", {31'd0, regRdata[4]}, 32'd1);
    flashRdyPin = 1'b0;
    repeat (2) @(negedge clk); #1;
    check("R2 ready low again", {31'd0, regRdata[4]}, 32'd0);

    // R9 all gating combinations
    for (int g = 0; g < 2; g++) begin
      for (int l = 0; l < 2; l++) begin
        writeCfg({28'd0, g[0], l[0], 2'b00});
        sdramPdEn = l[0];
        #1;
        check($sformatf("R9 imem g%0d l%0d", g, l), {31'd0, imemClkEn}, {31'd0, ~(g[0] & l[0])});
        check($sformatf("R9 sdram g%0d l%0d", g, l), {31'd0, sdramClkEn}, {31'd0, ~(g[0] & l[0])});
      end
    end
    sdramPdEn = 1'b0;

    // R10 idle handshake
    writeCfg(32'h0);
    @(negedge clk); idleReq = 1'b1;
    repeat (2) @(negedge clk); #1;
    check("R10 no ack without enable", {31'd0, idleAck}, 32'd0);
    idleReq = 1'b0;
    writeCfg(32'h4);
    @(negedge clk); idleReq = 1'b1; #1;
    check("R10 ack not in request cycle", {31'd0, idleAck}, 32'd0);
    @(negedge clk); #1;
    check("R10 ack one cycle later", {31'd0, idleAck}, 32'd1);
    idleReq = 1'b0; #1;
    check("R10 ack drops with request", {31'd0, idleAck}, 32'd0);
    idleReq = 1'b1;
    repeat (2) @(negedge clk); #1;
    check("R10 ack back", {31'd0, idleAck}, 32'd1);
    writeCfg(32'h0);
    check("R10 ack drops with enable", {31'd0, idleAck}, 32'd0);
    idleReq = 1'b0;

    // R5 strap low on a second reset
    doReset(1'b0);
    check("R5 reset boot strap low", {28'd0, regRdata[3:0]}, 32'h0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule